// File: doc/BRIEF.md
# Per-Flow Traffic Accounting Counter Table

This block keeps a packet counter and a byte counter for every offloaded flow index. A packet-event stream updates the counters. Each event carries a flow index, a count-enable flag and a packet length in bytes. An event transfers on any cycle where `evt_valid` and `evt_ready` are both high.

`evt_ready` is low while reset is asserted. It rises on the first clock after reset and then stays high, so the stream never applies back-pressure after that. A transferred event changes its flow's counters only when two conditions hold: the global enable is set, and the event's own count-enable flag is set. Each counting event adds one to the packet count and adds the packet length to the byte count. Both counters saturate at their maximum value and do not wrap.

Software uses a plain register port to work the block. To read a flow, it writes the flow index together with a start bit to the command register. It then polls the busy bit. When busy is clear, it collects a 48-bit byte count and a 40-bit packet count, which are spread over three 32-bit result registers. In read-clear mode, each completed read zeroes that flow's counters, so every read returns the traffic seen since the previous read.

Top module: `acct_counter_table`

## Requirements
- R1: While reset is asserted, and until the first read after it, `evt_ready` is 0, every counter is zero, the result registers read 0 and the busy bit reads 0.
- R2: One clock after reset is released, `evt_ready` is 1. Every event with the count-enable flag set adds 1 to its flow's packet count and adds `evt_len` to its flow's byte count, provided the global enable is set.
- R3: An event whose count-enable flag is 0 leaves every counter unchanged.
- R4: Bit 0 of the configuration register at 0x330 is the global enable. While it is 0, no event changes any counter.
- R5: The command register is at 0x33C. A write with bit 16 set starts a read of the flow whose index is in bits [13:0]. On a read of 0x33C, bit 16 is 1 for exactly two cycles after the write and then returns to 0, and bits [13:0] return the index being read.
- R6: Once busy clears, the results are laid out as follows. 0x340 holds byte count [31:0]. 0x344 holds byte count [47:32] in bits [15:0] and packet count [15:0] in bits [31:16]. 0x348 holds packet count [39:16] in bits [23:0]. The result registers change only when a read completes.
- R7: Bit 1 of the configuration register is the read-clear mode. When it is 1, a completed read zeroes that flow's counters. When it is 0, reads leave the counts accumulating.
- R8: A start written while busy is set is ignored. The index, the results and the counters of the other flow are unchanged.
- R9: A counting event for the same flow, in the same cycle that a read-clear completes, is counted after the clear. The read returns the count from before the event, and the following read returns the event alone.
- R10: The configuration register reads back its two written bits, and all its other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Packet event valid |
| evt_ready | output | 1 | Packet event ready (high from the first cycle after reset) |
| evt_flow | input | IDX_W | Flow index of the event |
| evt_count_en | input | 1 | Per-flow count-enable flag of the event |
| evt_len | input | LEN_W | Packet length in bytes |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 12 | Register write byte address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 12 | Register read byte address |
| reg_rd_data | output | 32 | Register read data (combinational from the read address) |

## Verification
A corrupted counter entry stays hidden until software reads that flow. It then shows as wrong fields in the result registers three cycles after the start is written. A fault in the read sequencer shows at once in the busy bit of the command register. The bit must read high on exactly the two polls after the write, and the index field must hold the flow being read. Faults in clear or merge ordering take two reads to expose. The first read returns the count from before the event, and only the second read shows whether the colliding packet survived.

// File: rtl/acct_pkg.sv
package acct_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int PKT_W = 40;
  localparam int BYTE_W = 48;
  localparam int CMD_IDX_W = 14;

  localparam logic [ADDR_W-1:0] OFF_CFG  = 12'h330;
  localparam logic [ADDR_W-1:0] OFF_CMD  = 12'h33C;
  localparam logic [ADDR_W-1:0] OFF_RES0 = 12'h340;
  localparam logic [ADDR_W-1:0] OFF_RES1 = 12'h344;
  localparam logic [ADDR_W-1:0] OFF_RES2 = 12'h348;

  localparam int CFG_EN_BIT = 0;
  localparam int CFG_RC_BIT = 1;
  localparam int CMD_START_BIT = 16;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_LATCH = 2'd1,
    ENG_CAPT  = 2'd2
  } eng_state_e;
endpackage

// File: rtl/acct_sat_add.sv
module acct_sat_add #(
  parameter int W  = 40,
  parameter int IW = 16
) (
  input  logic [W-1:0]  base,
  input  logic [IW-1:0] inc,
  output logic [W-1:0]  sum
);
  localparam int SW = W + 1;
  logic [SW-1:0] wide;

  assign wide = {1'b0, base} + SW'(inc);
  assign sum  = wide[W] ? {W{1'b1}} : wide[W-1:0];
endmodule

// File: rtl/acct_table.sv
module acct_table
  import acct_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_fire,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic [LEN_W-1:0]  upd_len,
  input  logic              clr_fire,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic [IDX_W-1:0]  look_idx,
  output logic [PKT_W-1:0]  look_pkt,
  output logic [BYTE_W-1:0] look_byte
);
  localparam int DEPTH = 1 << IDX_W;

  logic [PKT_W-1:0]  pkt_q  [DEPTH];
  logic [BYTE_W-1:0] byte_q [DEPTH];

  logic              merge_clr;
  logic [PKT_W-1:0]  pkt_base, pkt_next;
  logic [BYTE_W-1:0] byte_base, byte_next;

  // A clear on the updated entry takes effect before the add.
  assign merge_clr = clr_fire && (clr_idx == upd_idx);
  assign pkt_base  = merge_clr ? '0 : pkt_q[upd_idx];
  assign byte_base = merge_clr ? '0 : byte_q[upd_idx];

  acct_sat_add #(.W(PKT_W), .IW(1)) u_pkt_add (
    .base(pkt_base),
    .inc (1'b1),
    .sum (pkt_next)
  );

  acct_sat_add #(.W(BYTE_W), .IW(LEN_W)) u_byte_add (
    .base(byte_base),
    .inc (upd_len),
    .sum (byte_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        pkt_q[i]  <= '0;
        byte_q[i] <= '0;
      end
    end else begin
      if (clr_fire) begin
        pkt_q[clr_idx]  <= '0;
        byte_q[clr_idx] <= '0;
      end
      if (upd_fire) begin
        pkt_q[upd_idx]  <= pkt_next;
        byte_q[upd_idx] <= byte_next;
      end
    end
  end

  assign look_pkt  = pkt_q[look_idx];
  assign look_byte = byte_q[look_idx];
endmodule

// File: rtl/acct_read_engine.sv
module acct_read_engine
  import acct_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic              rd_clr,
  input  logic [PKT_W-1:0]  look_pkt,
  input  logic [BYTE_W-1:0] look_byte,
  output logic              busy,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              cap_fire,
  output logic              clr_fire,
  output logic [PKT_W-1:0]  res_pkt,
  output logic [BYTE_W-1:0] res_byte
);
  eng_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ENG_IDLE;
      cur_idx  <= '0;
      res_pkt  <= '0;
      res_byte <= '0;
    end else begin
      case (state_q)
        ENG_IDLE: begin
          if (start_req) begin
            cur_idx <= start_idx;
            state_q <= ENG_LATCH;
          end
        end
        ENG_LATCH: state_q <= ENG_CAPT;
        ENG_CAPT: begin
          res_pkt  <= look_pkt;
          res_byte <= look_byte;
          state_q  <= ENG_IDLE;
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != ENG_IDLE);
  assign cap_fire = (state_q == ENG_CAPT);
  assign clr_fire = cap_fire && rd_clr;
endmodule

// File: rtl/acct_regs.sv
module acct_regs
  import acct_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_wr_addr,
  input  logic [DATA_W-1:0] reg_wr_data,
  input  logic [ADDR_W-1:0] reg_rd_addr,
  output logic [DATA_W-1:0] reg_rd_data,
  output logic              cfg_en,
  output logic              cfg_rc,
  output logic              start_req,
  output logic [IDX_W-1:0]  start_idx,
  input  logic              busy,
  input  logic [IDX_W-1:0]  cur_idx,
  input  logic [PKT_W-1:0]  res_pkt,
  input  logic [BYTE_W-1:0] res_byte
);
  logic unused_wdata;
  assign unused_wdata = ^reg_wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en <= 1'b0;
      cfg_rc <= 1'b0;
    end else if (reg_wr_en && reg_wr_addr == OFF_CFG) begin
      cfg_en <= reg_wr_data[CFG_EN_BIT];
      cfg_rc <= reg_wr_data[CFG_RC_BIT];
    end
  end

  assign start_req = reg_wr_en && (reg_wr_addr == OFF_CMD) && reg_wr_data[CMD_START_BIT];
  assign start_idx = reg_wr_data[IDX_W-1:0];

  always_comb begin
    reg_rd_data = '0;
    case (reg_rd_addr)
      OFF_CFG: begin
        reg_rd_data[CFG_EN_BIT] = cfg_en;
        reg_rd_data[CFG_RC_BIT] = cfg_rc;
      end
      OFF_CMD: begin
        reg_rd_data[CMD_IDX_W-1:0] = CMD_IDX_W'(cur_idx);
        reg_rd_data[CMD_START_BIT] = busy;
      end
      OFF_RES0: reg_rd_data = res_byte[31:0];
      OFF_RES1: reg_rd_data = {res_pkt[15:0], res_byte[47:32]};
      OFF_RES2: reg_rd_data = {8'h00, res_pkt[39:16]};
      default:  reg_rd_data = '0;
    endcase
  end
endmodule

// File: rtl/acct_counter_table.sv
module acct_counter_table
  import acct_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [IDX_W-1:0]  evt_flow,
  input  logic              evt_count_en,
  input  logic [LEN_W-1:0]  evt_len,
  input  logic              reg_wr_en,
  input  logic [11:0]       reg_wr_addr,
  input  logic [31:0]       reg_wr_data,
  input  logic [11:0]       reg_rd_addr,
  output logic [31:0]       reg_rd_data
);
  logic              ready_q;
  logic              cfg_en, cfg_rc;
  logic              start_req;
  logic [IDX_W-1:0]  start_idx;
  logic              eng_busy, cap_fire, clr_fire, upd_fire;
  logic [IDX_W-1:0]  eng_idx;
  logic [PKT_W-1:0]  look_pkt, res_pkt;
  logic [BYTE_W-1:0] look_byte, res_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign evt_ready = ready_q;
  assign upd_fire  = evt_valid && ready_q && evt_count_en && cfg_en;

  acct_regs #(.IDX_W(IDX_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr),
    .reg_rd_data(reg_rd_data),
    .cfg_en     (cfg_en),
    .cfg_rc     (cfg_rc),
    .start_req  (start_req),
    .start_idx  (start_idx),
    .busy       (eng_busy),
    .cur_idx    (eng_idx),
    .res_pkt    (res_pkt),
    .res_byte   (res_byte)
  );

  acct_read_engine #(.IDX_W(IDX_W)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_req(start_req),
    .start_idx(start_idx),
    .rd_clr   (cfg_rc),
    .look_pkt (look_pkt),
    .look_byte(look_byte),
    .busy     (eng_busy),
    .cur_idx  (eng_idx),
    .cap_fire (cap_fire),
    .clr_fire (clr_fire),
    .res_pkt  (res_pkt),
    .res_byte (res_byte)
  );

  acct_table #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_fire (upd_fire),
    .upd_idx  (evt_flow),
    .upd_len  (evt_len),
    .clr_fire (clr_fire),
    .clr_idx  (eng_idx),
    .look_idx (eng_idx),
    .look_pkt (look_pkt),
    .look_byte(look_byte)
  );
endmodule

// File: rtl/acct_counter_table_chk.sv
module acct_counter_table_chk
  import acct_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              start_req,
  input logic [IDX_W-1:0]  cur_idx,
  input logic              cap_fire,
  input logic [PKT_W-1:0]  res_pkt,
  input logic [BYTE_W-1:0] res_byte,
  input logic              evt_ready
);
  // R2: the stream is ready once out of reset
  p_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> evt_ready);

  // R5: busy lasts a second cycle once raised
  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);

  // R5: the second busy cycle is the capture cycle
  p_busy_capt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> cap_fire);

  // R5: busy drops right after the capture
  p_busy_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> !busy);

  // R8: a start during busy does not move the index
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_req) |=> $stable(cur_idx));

  // R6: results change only on a completed read
  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_fire |=> ($stable(res_pkt) && $stable(res_byte)));
endmodule

bind acct_counter_table acct_counter_table_chk #(.IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (eng_busy),
  .start_req(start_req),
  .cur_idx  (eng_idx),
  .cap_fire (cap_fire),
  .res_pkt  (res_pkt),
  .res_byte (res_byte),
  .evt_ready(evt_ready)
);

// File: tb/acct_counter_table_tb.sv
`timescale 1ns/1ps
module acct_counter_table_tb;
  localparam int IDX_W = 8;
  localparam int LEN_W = 16;
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [11:0] A_CFG = 12'h330, A_CMD = 12'h33C;
  localparam logic [11:0] A_R0 = 12'h340, A_R1 = 12'h344, A_R2 = 12'h348;
  localparam int NVEC = 10;
  // {flow, count_en, len}
  localparam logic [24:0] VECS [NVEC] = '{
    {8'd3,  1'b1, 16'd64},   {8'd3,  1'b1, 16'd1500},
    {8'd7,  1'b1, 16'd40},   {8'd3,  1'b0, 16'd999},
    {8'd9,  1'b0, 16'd512},  {8'd7,  1'b1, 16'd65535},
    {8'd12, 1'b1, 16'd0},    {8'd12, 1'b1, 16'd100},
    {8'd12, 1'b1, 16'd9000}, {8'd3,  1'b1, 16'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_valid = 1'b0, evt_ready, evt_count_en = 1'b0;
  logic [IDX_W-1:0] evt_flow = '0;
  logic [LEN_W-1:0] evt_len = '0;
  logic reg_wr_en = 1'b0;
  logic [11:0] reg_wr_addr = '0, reg_rd_addr = '0;
  logic [31:0] reg_wr_data = '0, reg_rd_data;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit m_en = 1'b0, m_rc = 1'b0;
  longint exp_pkt [DEPTH];
  longint exp_byte [DEPTH];

  always #2.5 clk = ~clk;

  acct_counter_table #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_flow(evt_flow),
    .evt_count_en(evt_count_en), .evt_len(evt_len),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
    reg_rd_addr = a;
    #1;
    d = reg_rd_data;
  endtask

  task automatic set_cfg(input bit en, input bit rc);
    reg_write(A_CFG, {30'd0, rc, en});
    m_en = en; m_rc = rc;
  endtask

  task automatic model_evt(input int f, input bit ce, input int len);
    if (ce && m_en) begin
      exp_pkt[f]++;
      exp_byte[f] += len;
    end
  endtask

  task automatic send_evt(input int f, input bit ce, input int len);
    @(negedge clk);
    evt_valid = 1'b1; evt_flow = IDX_W'(f); evt_count_en = ce; evt_len = LEN_W'(len);
    model_evt(f, ce, len);
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic collect(output longint p, output longint b);
    logic [31:0] r0, r1, r2;
    reg_read(A_R0, r0); reg_read(A_R1, r1); reg_read(A_R2, r2);
    p = {r2[23:0], r1[31:16]};
    b = {r1[15:0], r0};
  endtask

  // Read a flow, checking busy timing (R5); returns assembled counts (R6)
  task automatic do_read(input int f, output longint p, output longint b);
    logic [31:0] c;
    reg_write(A_CMD, 32'h0001_0000 | f);
    reg_read(A_CMD, c); chk("R5 busy poll 1", c[16], 1);
    chk("R5 index field", c[13:0], f);
    @(negedge clk);
    reg_read(A_CMD, c); chk("R5 busy poll 2", c[16], 1);
    @(negedge clk);
    reg_read(A_CMD, c); chk("R5 busy cleared", c[16], 0);
    collect(p, b);
    if (m_rc) begin
      exp_pkt[f] = 0; exp_byte[f] = 0;
    end
  endtask

  task automatic read_check(input string tag, input int f);
    longint ep, eb, p, b;
    ep = exp_pkt[f]; eb = exp_byte[f];
    do_read(f, p, b);
    chk({tag, " packets"}, p, ep);
    chk({tag, " bytes"}, b, eb);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    longint p, b, ep, eb;
    for (int i = 0; i < DEPTH; i++) begin exp_pkt[i] = 0; exp_byte[i] = 0; end

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", evt_ready, 0);
    reg_read(A_CMD, d); chk("R1 busy in reset", d[16], 0);
    reg_read(A_R1, d);  chk("R1 result reg", d, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 ready after reset", evt_ready, 1);
    read_check("R1 counters zero", 5);

    // R10: configuration readback
    set_cfg(1'b1, 1'b1);
    reg_read(A_CFG, d); chk("R10 cfg readback 3", d, 3);
    set_cfg(1'b1, 1'b0);
    reg_read(A_CFG, d); chk("R10 cfg readback 1", d, 1);

    // R2/R3: vector table walk
    for (int v = 0; v < NVEC; v++)
      send_evt(VECS[v][24:17], VECS[v][16], VECS[v][15:0]);
    read_check("R2 flow 3", 3);
    read_check("R2 flow 7", 7);
    read_check("R2 flow 12", 12);
    read_check("R3 flag clear flow 9", 9);

    // R4: global enable off
    set_cfg(1'b0, 1'b0);
    send_evt(7, 1'b1, 300);
    set_cfg(1'b1, 1'b0);
    read_check("R4 disabled no count", 7);

    // R7: accumulate mode, then read-clear mode
    send_evt(7, 1'b1, 10);
    read_check("R7 accumulate read 1", 7);
    read_check("R7 accumulate read 2", 7);
    set_cfg(1'b1, 1'b1);
    read_check("R7 clear read full", 7);
    read_check("R7 clear read zero", 7);
    send_evt(7, 1'b1, 77);
    read_check("R7 delta read", 7);

    // R8: start while busy is ignored
    send_evt(20, 1'b1, 200);
    send_evt(21, 1'b1, 333);
    ep = exp_pkt[20]; eb = exp_byte[20];
    reg_write(A_CMD, 32'h0001_0014);
    reg_wr_en = 1'b1; reg_wr_addr = A_CMD; reg_wr_data = 32'h0001_0015;
    @(negedge clk);
    reg_wr_en = 1'b0;
    @(negedge clk);
    reg_read(A_CMD, d);
    chk("R8 busy done", d[16], 0);
    chk("R8 index kept", d[13:0], 20);
    collect(p, b);
    chk("R8 results of first flow pkts", p, ep);
    chk("R8 results of first flow bytes", b, eb);
    exp_pkt[20] = 0; exp_byte[20] = 0;
    read_check("R8 second flow untouched", 21);

    // R9: event and clear on the same flow in the same cycle
    send_evt(30, 1'b1, 50);
    ep = exp_pkt[30]; eb = exp_byte[30];
    reg_write(A_CMD, 32'h0001_001E);
    @(negedge clk);
    evt_valid = 1'b1; evt_flow = 8'd30; evt_count_en = 1'b1; evt_len = 16'd123;
    @(negedge clk);
    evt_valid = 1'b0;
    collect(p, b);
    chk("R9 read before event pkts", p, ep);
    chk("R9 read before event bytes", b, eb);
    exp_pkt[30] = 1; exp_byte[30] = 123;
    read_check("R9 event kept after clear", 30);

    // R6: field split with counts past 32-bit bytes and 16-bit packets
    set_cfg(1'b1, 1'b0);
    @(negedge clk);
    evt_valid = 1'b1; evt_flow = 8'd200; evt_count_en = 1'b1; evt_len = 16'hFFFF;
    for (int k = 0; k < 70000; k++) begin
      model_evt(200, 1'b1, 65535);
      @(negedge clk);
    end
    evt_valid = 1'b0;
    ep = exp_pkt[200]; eb = exp_byte[200];
    do_read(200, p, b);
    reg_read(A_R0, d); chk("R6 res0 byte low", d, eb & 64'hFFFF_FFFF);
    reg_read(A_R1, d); chk("R6 res1 split", d, ((ep & 64'hFFFF) << 16) | ((eb >> 32) & 64'hFFFF));
    reg_read(A_R2, d); chk("R6 res2 pkt high", d, (ep >> 16) & 64'hFF_FFFF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule